// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one warp load request, made of 32 per-lane byte addresses and an active-lane mask. It merges the active lanes into the smallest set of aligned 128-byte line transactions. All lanes whose addresses fall in the same 128-byte line share one transaction. When lanes read consecutive elements, the request needs one transaction. When every lane reads the same word, the request also needs one transaction, and that word is broadcast to every lane. When lanes are spread one line apart, the request needs one transaction per lane.

The transactions leave one per cycle over a valid/ready handshake, lowest line address first. Each transaction carries the line-aligned address, the set of lanes it serves, and each served lane's byte offset inside the line. It also carries a flag that marks the final transaction of the request.

After the final transaction, a one-cycle completion report gives three values: the number of transactions, the useful bytes (active lanes times the element size), and the transferred bytes (transactions times the line size). Efficiency is the ratio of useful bytes to transferred bytes. Lanes that are not active produce no traffic. Lane addresses are assumed aligned to the 4-byte element size.

Top module: `coal_warp_coalescer`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `txn_valid` is 0 and `done_valid` is 0.
- R2: Each transaction's `txn_addr` is the line address with its low 7 bits zero. Its `txn_lanes` bit i is 1 exactly for the pending active lanes whose address bits [31:7] equal that line. It always serves at least one lane.
- R3: Thirty-two active lanes reading consecutive 4-byte words from a 128-byte-aligned base produce exactly one transaction.
- R4: Thirty-two active lanes reading the same address produce exactly one transaction. That transaction serves all lanes, and every lane has the same offset.
- R5: Thirty-two active lanes whose addresses are 128 bytes apart produce exactly 32 transactions.
- R6: Within a request, transactions leave in strictly ascending line-address order.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, the transaction address, lane set and offsets stay unchanged.
- R8: A lane whose bit in `req_mask` is 0 never appears in any `txn_lanes`. It adds to neither count, whatever its address.
- R9: Across one request, the `txn_lanes` sets are disjoint and their union equals `req_mask`.
- R10: `txn_offsets` field i (bits [7i+6:7i]) equals lane i's address bits [6:0] when lane i is served by the current transaction, and zero otherwise.
- R11: `done_valid` pulses in the cycle after the final handshake. `done_txn_count` is the number of transactions. `done_req_bytes` is 4 times the number of active lanes. `done_xfer_bytes` is 128 times the count. The useful bytes never exceed the transferred bytes.
- R12: A request with an all-zero mask produces no transaction. `done_valid` is 1 in the next cycle, with all three counts zero.
- R13: `req_ready` is 0 from the accepting edge of a non-empty request until its final handshake. It returns to 1 in the following cycle.
- R14: `txn_last` is 1 only on the final transaction of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle; request accepted when valid is also high |
| req_addr | input | 1024 | Lane i byte address in bits [32i+31:32i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_addr | output | 32 | Line-aligned transaction address |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_offsets | output | 224 | Per-lane 7-bit byte offset within the line |
| txn_last | output | 1 | Final transaction of the request |
| done_valid | output | 1 | One-cycle completion report |
| done_txn_count | output | 6 | Transactions issued for the request |
| done_req_bytes | output | 13 | Useful bytes requested |
| done_xfer_bytes | output | 13 | Bytes moved by the transactions |

## Verification
The first transaction is due in the cycle after the accepting edge, because only the captured lane state lies between the request and the transaction outputs. Each further transaction is due in the cycle after the previous handshake. The completion report is due in the cycle after the final handshake, or in the cycle after acceptance for an empty mask. The bench drives its inputs and samples the outputs on the falling edge. After each handshake it advances exactly one cycle before comparing the next transaction or report against its own line-grouping model. During a stall it rechecks the same expected transaction every cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int DEF_LANES      = 32;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_BYTES = 128;
    localparam int DEF_ELEM_BYTES = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } coal_state_e;

endpackage

// File: rtl/coal_min_seg.sv
module coal_min_seg #(
    parameter int LANES = 32,
    parameter int SEG_W = 25
) (
    input  logic [LANES*SEG_W-1:0] seg_flat,
    input  logic [LANES-1:0]       seg_vld,
    output logic [SEG_W-1:0]       min_seg,
    output logic                   any_vld
);
    localparam int P     = 1 << $clog2(LANES);
    localparam int NODES = 2 * P - 1;

    logic [SEG_W-1:0] nseg [NODES];
    logic             nvld [NODES];

    genvar g;
    generate
        for (g = 0; g < P; g++) begin : g_leaf
            if (g < LANES) begin : g_real
                assign nseg[P-1+g] = seg_flat[g*SEG_W +: SEG_W];
                assign nvld[P-1+g] = seg_vld[g];
            end else begin : g_pad
                assign nseg[P-1+g] = '0;
                assign nvld[P-1+g] = 1'b0;
            end
        end
        for (g = 0; g < P - 1; g++) begin : g_node
            logic take_left;
            assign take_left = nvld[2*g+1] &&
                               (!nvld[2*g+2] || (nseg[2*g+1] <= nseg[2*g+2]));
            assign nseg[g]   = take_left ? nseg[2*g+1] : nseg[2*g+2];
            assign nvld[g]   = nvld[2*g+1] || nvld[2*g+2];
        end
    endgenerate

    assign min_seg = nseg[0];
    assign any_vld = nvld[0];

endmodule

// File: rtl/coal_match.sv
module coal_match #(
    parameter int LANES = 32,
    parameter int SEG_W = 25,
    parameter int OFS_W = 7
) (
    input  logic [LANES*SEG_W-1:0] seg_flat,
    input  logic [LANES*OFS_W-1:0] ofs_flat,
    input  logic [LANES-1:0]       pend,
    input  logic [SEG_W-1:0]       sel_seg,
    output logic [LANES-1:0]       hit,
    output logic [LANES*OFS_W-1:0] hit_ofs
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign hit[g] = pend[g] && (seg_flat[g*SEG_W +: SEG_W] == sel_seg);
            assign hit_ofs[g*OFS_W +: OFS_W] =
                hit[g] ? ofs_flat[g*OFS_W +: OFS_W] : '0;
        end
    endgenerate

endmodule

// File: rtl/coal_stats.sv
module coal_stats #(
    parameter int LANES      = 32,
    parameter int LINE_BYTES = 128,
    parameter int ELEM_BYTES = 4,
    parameter int CNT_W      = 6,
    parameter int BYTES_W    = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [LANES-1:0]   accept_mask,
    input  logic               send,
    input  logic               send_last,
    output logic               done_valid,
    output logic [CNT_W-1:0]   done_txn_count,
    output logic [BYTES_W-1:0] done_req_bytes,
    output logic [BYTES_W-1:0] done_xfer_bytes
);
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTES_W-1:0] req_bytes_q;
    logic [CNT_W-1:0]   active_cnt;
    logic [CNT_W-1:0]   cnt_next;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < LANES; i++) begin
            active_cnt = active_cnt + CNT_W'(accept_mask[i]);
        end
    end

    assign cnt_next = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q           <= '0;
            req_bytes_q     <= '0;
            done_valid      <= 1'b0;
            done_txn_count  <= '0;
            done_req_bytes  <= '0;
            done_xfer_bytes <= '0;
        end else begin
            done_valid <= 1'b0;
            if (accept) begin
                cnt_q       <= '0;
                req_bytes_q <= BYTES_W'(active_cnt) * BYTES_W'(ELEM_BYTES);
                if (accept_mask == '0) begin
                    done_valid      <= 1'b1;
                    done_txn_count  <= '0;
                    done_req_bytes  <= '0;
                    done_xfer_bytes <= '0;
                end
            end else if (send) begin
                cnt_q <= cnt_next;
                if (send_last) begin
                    done_valid      <= 1'b1;
                    done_txn_count  <= cnt_next;
                    done_req_bytes  <= req_bytes_q;
                    done_xfer_bytes <= BYTES_W'(cnt_next) * BYTES_W'(LINE_BYTES);
                end
            end
        end
    end

    // R11
    eff_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_req_bytes <= done_xfer_bytes));

    // R11
    done_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        send && send_last |=> done_valid && (done_txn_count != '0));

endmodule

// File: rtl/coal_warp_coalescer.sv
module coal_warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = DEF_LANES,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int ELEM_BYTES = DEF_ELEM_BYTES,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int SEG_W     = ADDR_W - OFS_W,
    localparam int CNT_W     = $clog2(LANES + 1),
    localparam int BYTES_W   = $clog2(LANES * LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [LANES-1:0]        txn_lanes,
    output logic [LANES*OFS_W-1:0]  txn_offsets,
    output logic                    txn_last,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_txn_count,
    output logic [BYTES_W-1:0]      done_req_bytes,
    output logic [BYTES_W-1:0]      done_xfer_bytes
);
    coal_state_e            state_q;
    logic [LANES-1:0]       pend_q;
    logic [LANES-1:0]       mask_q;
    logic [LANES*SEG_W-1:0] seg_q;
    logic [LANES*OFS_W-1:0] ofs_q;

    logic                   accept;
    logic                   send;
    logic [SEG_W-1:0]       min_seg;
    logic                   any_pend;
    logic [LANES-1:0]       hit;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state_q == ST_SEND);
    assign send      = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++) begin
                seg_q[i*SEG_W +: SEG_W] <= req_addr[i*ADDR_W+OFS_W +: SEG_W];
                ofs_q[i*OFS_W +: OFS_W] <= req_addr[i*ADDR_W +: OFS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            pend_q  <= req_mask;
            mask_q  <= req_mask;
            state_q <= (req_mask != '0) ? ST_SEND : ST_IDLE;
        end else if (send) begin
            pend_q <= pend_q & ~hit;
            if (txn_last) begin
                state_q <= ST_IDLE;
            end
        end
    end

    coal_min_seg #(
        .LANES (LANES),
        .SEG_W (SEG_W)
    ) u_min (
        .seg_flat (seg_q),
        .seg_vld  (pend_q),
        .min_seg  (min_seg),
        .any_vld  (any_pend)
    );

    coal_match #(
        .LANES (LANES),
        .SEG_W (SEG_W),
        .OFS_W (OFS_W)
    ) u_match (
        .seg_flat (seg_q),
        .ofs_flat (ofs_q),
        .pend     (pend_q),
        .sel_seg  (min_seg),
        .hit      (hit),
        .hit_ofs  (txn_offsets)
    );

    assign txn_addr  = {min_seg, {OFS_W{1'b0}}};
    assign txn_lanes = hit;
    assign txn_last  = txn_valid && ((pend_q & ~hit) == '0);

    coal_stats #(
        .LANES      (LANES),
        .LINE_BYTES (LINE_BYTES),
        .ELEM_BYTES (ELEM_BYTES),
        .CNT_W      (CNT_W),
        .BYTES_W    (BYTES_W)
    ) u_stats (
        .clk             (clk),
        .rst             (rst),
        .accept          (accept),
        .accept_mask     (req_mask),
        .send            (send),
        .send_last       (txn_last),
        .done_valid      (done_valid),
        .done_txn_count  (done_txn_count),
        .done_req_bytes  (done_req_bytes),
        .done_xfer_bytes (done_xfer_bytes)
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
                                    && $stable(txn_lanes) && $stable(txn_offsets));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_ready && !txn_last |=> txn_valid && (txn_addr > $past(txn_addr)));

    // R2
    lanes_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> any_pend && (txn_lanes != '0));

    // R8
    lanes_subset_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((txn_lanes & ~mask_q) == '0));

    // R12
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        accept && (req_mask == '0) |=> done_valid && !txn_valid && (done_txn_count == '0));

    // R13
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        accept && (req_mask != '0) |=> !req_ready);

endmodule

// File: tb/coal_warp_coalescer_bench.sv
module coal_warp_coalescer_bench;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int OW    = 7;
    localparam int CW    = 6;
    localparam int BW    = 13;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [LANES*AW-1:0] req_addr;
    logic [LANES-1:0]  req_mask;
    logic              txn_valid;
    logic              txn_ready;
    logic [AW-1:0]     txn_addr;
    logic [LANES-1:0]  txn_lanes;
    logic [LANES*OW-1:0] txn_offsets;
    logic              txn_last;
    logic              done_valid;
    logic [CW-1:0]     done_txn_count;
    logic [BW-1:0]     done_req_bytes;
    logic [BW-1:0]     done_xfer_bytes;

    always #5 clk = ~clk;

    coal_warp_coalescer u_coal_warp_coalescer (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_mask (req_mask),
        .txn_valid (txn_valid), .txn_ready (txn_ready),
        .txn_addr (txn_addr), .txn_lanes (txn_lanes),
        .txn_offsets (txn_offsets), .txn_last (txn_last),
        .done_valid (done_valid), .done_txn_count (done_txn_count),
        .done_req_bytes (done_req_bytes), .done_xfer_bytes (done_xfer_bytes)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] la [LANES];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [24:0] ref_min(input logic [31:0] pend);
        logic [24:0] m = '1;
        for (int i = 0; i < LANES; i++)
            if (pend[i] && la[i][31:7] < m) m = la[i][31:7];
        return m;
    endfunction

    function automatic logic [31:0] ref_lanes(input logic [31:0] pend, input logic [24:0] s);
        logic [31:0] r = '0;
        for (int i = 0; i < LANES; i++)
            if (pend[i] && la[i][31:7] == s) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [LANES*OW-1:0] ref_ofs(input logic [31:0] ln);
        logic [LANES*OW-1:0] r = '0;
        for (int i = 0; i < LANES; i++)
            if (ln[i]) r[i*OW +: OW] = la[i][6:0];
        return r;
    endfunction

    // Issues one request at a falling edge and follows it to completion.
    task automatic run_req(input logic [31:0] mask, input int ready_pct, output int n);
        logic [31:0] pend;
        logic [24:0] ms;
        logic [31:0] el;
        int act;
        bit stalled;
        n = 0;
        act = $countones(mask);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
        req_mask  = mask;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R13", "ready before request", 256'(req_ready), 256'(1));
        @(negedge clk);
        req_valid = 1'b0;
        if (mask == '0) begin
            chk(done_valid == 1'b1, "R12", "empty done", 256'(done_valid), 256'(1));
            chk(done_txn_count == 0 && done_req_bytes == 0 && done_xfer_bytes == 0,
                "R12", "empty counts", 256'({done_txn_count, done_req_bytes, done_xfer_bytes}), 256'(0));
            chk(txn_valid == 1'b0, "R12", "empty no txn", 256'(txn_valid), 256'(0));
            return;
        end
        chk(req_ready == 1'b0, "R13", "busy after accept", 256'(req_ready), 256'(0));
        pend = mask;
        stalled = 1'b0;
        while (pend != '0) begin
            ms = ref_min(pend);
            el = ref_lanes(pend, ms);
            chk(txn_valid == 1'b1, "R2", "txn valid", 256'(txn_valid), 256'(1));
            chk(txn_addr == {ms, 7'b0}, stalled ? "R7" : "R6", "txn addr",
                256'(txn_addr), 256'({ms, 7'b0}));
            chk(txn_lanes == el, stalled ? "R7" : "R9", "txn lanes",
                256'(txn_lanes), 256'(el));
            chk(txn_offsets == ref_ofs(el), "R10", "txn offsets",
                256'(txn_offsets), 256'(ref_ofs(el)));
            chk(txn_last == ((pend & ~el) == '0), "R14", "txn last",
                256'(txn_last), 256'((pend & ~el) == '0));
            chk(req_ready == 1'b0, "R13", "no accept while busy", 256'(req_ready), 256'(0));
            txn_ready = ($urandom_range(99) < ready_pct);
            @(negedge clk);
            if (txn_ready) begin
                pend &= ~el;
                n++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
            end
        end
        txn_ready = 1'b0;
        chk(done_valid == 1'b1, "R11", "done pulse", 256'(done_valid), 256'(1));
        chk(done_txn_count == CW'(n), "R11", "txn count", 256'(done_txn_count), 256'(n));
        chk(done_req_bytes == BW'(act * 4), "R11", "req bytes", 256'(done_req_bytes), 256'(act * 4));
        chk(done_xfer_bytes == BW'(n * 128), "R11", "xfer bytes", 256'(done_xfer_bytes), 256'(n * 128));
        chk(done_req_bytes <= done_xfer_bytes, "R11", "efficiency bound",
            256'(done_req_bytes), 256'(done_xfer_bytes));
        chk(txn_valid == 1'b0 && req_ready == 1'b1, "R13", "idle after last",
            256'({txn_valid, req_ready}), 256'(1));
    endtask

    initial begin
        int n;
        logic [31:0] base;
        void'($urandom(32'h5eed_c0a1));
        rst = 1'b1; req_valid = 1'b0; req_mask = '0; req_addr = '0; txn_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done_valid == 1'b0, "R1", "in reset",
            256'({req_ready, txn_valid, done_valid}), 256'(3'b100));
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && txn_valid == 1'b0 && done_valid == 1'b0, "R1", "after reset",
            256'({req_ready, txn_valid, done_valid}), 256'(3'b100));

        // R3 contiguous aligned
        base = 32'h0004_0000;
        for (int i = 0; i < LANES; i++) la[i] = base + 32'(4 * i);
        run_req('1, 100, n);
        chk(n == 1, "R3", "contiguous count", 256'(n), 256'(1));

        // R4 broadcast
        for (int i = 0; i < LANES; i++) la[i] = 32'h1234_5678;
        run_req('1, 60, n);
        chk(n == 1, "R4", "broadcast count", 256'(n), 256'(1));

        // R5 one line apart, and reversed for R6
        for (int i = 0; i < LANES; i++) la[i] = 32'h0010_0000 + 32'(128 * i);
        run_req('1, 70, n);
        chk(n == 32, "R5", "strided count", 256'(n), 256'(32));
        for (int i = 0; i < LANES; i++) la[i] = 32'h0020_0000 + 32'(128 * (31 - i));
        run_req('1, 50, n);
        chk(n == 32, "R6", "reversed strided count", 256'(n), 256'(32));

        // R8 tail guard: inactive lanes point at far lines
        for (int i = 0; i < LANES; i++)
            la[i] = (i < 20) ? 32'h0030_0000 + 32'(4 * i) : 32'(128 * i);
        run_req(32'h000F_FFFF, 80, n);
        chk(n == 1, "R8", "tail guard count", 256'(n), 256'(1));

        // R12 empty
        run_req('0, 100, n);

        // contiguous crossing a line
        for (int i = 0; i < LANES; i++) la[i] = 32'h0040_0040 + 32'(4 * i);
        run_req('1, 100, n);
        chk(n == 2, "R2", "unaligned contiguous count", 256'(n), 256'(2));

        // random mix
        for (int t = 0; t < 400; t++) begin
            int kind = $urandom_range(4);
            int stride = $urandom_range(1, 40);
            logic [31:0] m;
            base = $urandom() & 32'hFFFF_FFFC;
            for (int i = 0; i < LANES; i++) begin
                case (kind)
                    0: la[i] = base + 32'(4 * i);
                    1: la[i] = base;
                    2: la[i] = base + 32'(4 * stride * i);
                    3: la[i] = (base & 32'hFFFF_F000) + ($urandom_range(1023) & 32'hFFC);
                    default: la[i] = $urandom() & 32'hFFFF_FFFC;
                endcase
            end
            case ($urandom_range(3))
                0: m = '1;
                1: m = 32'hFFFF_FFFF >> $urandom_range(31);
                2: m = '0;
                default: m = $urandom();
            endcase
            run_req(m, $urandom_range(30, 100), n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule